// File: doc/BRIEF.md
# Byte-Lane Pipelined Synchronous SRAM

This block is a single-port synchronous memory for a data path that needs byte-granular writes and a registered, pipelined read. Each storage lane is nine bits wide, eight data bits and one parity bit. The default configuration has four lanes, a 36-bit word. Address, write data, chip select and every write control are captured on the rising clock edge. A read presents its word on the data outputs one edge after its address is captured. A write needs nothing further from the outside once its controls have been captured.

Writes are posted. A captured write waits in a one-entry buffer and moves into the array when the next write is captured. A read that hits the buffered address takes the buffered lanes in place of the array lanes, one lane at a time. A read issued in the cycle right after a write therefore returns the new bytes. The output bus is controlled by a three-state output machine with these states:

- `OUT_OFF`: bus released.
- `OUT_DRIVE`: bus shows read data.
- `OUT_HOLD`: a deselect has been seen and the bus is driven for one more cycle.

Its transitions are:

- read: any state to `OUT_DRIVE`.
- write: `OUT_DRIVE` to `OUT_OFF`.
- deselect: `OUT_DRIVE` to `OUT_HOLD`.
- deselect or write: `OUT_HOLD` to `OUT_OFF`.
- no read: `OUT_OFF` stays in `OUT_OFF`.

An asynchronous output enable gates the bus on top of this.

Top module: `lane_sram`

## Requirements
- R1: A word is LANES lanes of 9 bits each, and lane l occupies bits [9l+8:9l] of `dq_i` and `dq_o`. Bit 9l+8 is that lane's parity bit.
- R2: With `gw_n`=1 and `bwe_n`=0, a selected cycle writes exactly the lanes whose `bw_n` bit is 0. All other lanes of that word keep their previous value, including after the write has moved from the buffer into the array.
- R3: With `gw_n`=1 and `bwe_n`=1, the `bw_n` bits have no effect. The cycle is a read and the addressed word is unchanged.
- R4: With `gw_n`=0, a selected cycle writes all lanes, whatever the values of `bwe_n` and `bw_n`.
- R5: Take a read whose address is captured at edge K. Its word appears on `dq_o` with `dq_oe`=1 after edge K+1, and stays there until the next read.
- R6: A read captured on the edge right after a write to the same address returns the newly written lanes, merged with the old contents of the unwritten lanes.
- R7: `oe_n`=1 forces `dq_oe` to 0 and `dq_o` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores the driven word at once.
- R8: A deselect (`ce_n`=1) captured at edge K, after a read, keeps the bus driven with the same word after edge K+1. The bus is released after edge K+2 if the cycle is still deselected.
- R9: A write captured at edge K releases the bus after edge K+1.
- R10: While reset is held and after it is released, `dq_oe` is 0 until a read has been captured.
- R11: A deselected cycle writes nothing, even when `gw_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low, captured on the clock |
| addr | input | ADDR_W | Word address, captured on the clock |
| gw_n | input | 1 | Global write, active low: writes all lanes |
| bwe_n | input | 1 | Master enable for the per-lane write bits, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*9 | Write data, captured on the clock |
| dq_o | output | LANES*9 | Read data, 0 while the bus is released |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with four lanes and a five-bit address. This puts the parity bit of the top lane, bit 35, within reach of the lane-position checks. The small word count keeps a reference copy of the whole memory cheap to hold in the bench. Write sequences exercise three cases: a buffered write hit by a read in the very next cycle, a buffered write moved into the array by a later write, and partial writes merged over a full one.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
    localparam int LANE_BITS = 9;

    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        OUT_OFF   = 2'd0,
        OUT_DRIVE = 2'd1,
        OUT_HOLD  = 2'd2
    } ost_e;
endpackage

// File: rtl/lane_sram_wmask.sv
module lane_sram_wmask #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);
    // Global write overrides everything; per-lane bits count only under the master enable.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !gw_n || (!bwe_n && !bw_n[g]);
    end
endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array
    import lane_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  op_e                      op,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_BITS-1:0] wdata,
    input  logic [LANES-1:0]         wmask,
    output logic [LANES*LANE_BITS-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int W     = LANES * LANE_BITS;

    logic              wb_vld;
    logic [ADDR_W-1:0] wb_addr;
    logic [W-1:0]      wb_data;
    logic [LANES-1:0]  wb_mask;
    logic              hit;

    assign hit = wb_vld && (wb_addr == addr);

    // Posted write buffer: refilled by every write, drained into the array at the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_vld  <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
            wb_mask <= '0;
        end else if (op == OP_WRITE) begin
            wb_vld  <= 1'b1;
            wb_addr <= addr;
            wb_data <= wdata;
            wb_mask <= wmask;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_BITS-1:0] mem [DEPTH];
        logic [LANE_BITS-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (op == OP_WRITE && wb_vld && wb_mask[g])
                mem[wb_addr] <= wb_data[g*LANE_BITS +: LANE_BITS];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_q <= '0;
            else if (op == OP_READ)
                rd_q <= (hit && wb_mask[g]) ? wb_data[g*LANE_BITS +: LANE_BITS] : mem[addr];
        end

        assign rdata[g*LANE_BITS +: LANE_BITS] = rd_q;
    end

    // R5: read data only moves on a read
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_READ) |=> $stable(rdata));

    // R6: a read hitting the buffer returns buffered lane 0 when it was written
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && hit && wb_mask[0]) |=> (rdata[LANE_BITS-1:0] == $past(wb_data[LANE_BITS-1:0])));
endmodule

// File: rtl/lane_sram_outctl.sv
module lane_sram_outctl
    import lane_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    output logic drive
);
    ost_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_OFF:   state_nx = (op == OP_READ) ? OUT_DRIVE : OUT_OFF;
            OUT_DRIVE: begin
                unique case (op)
                    OP_READ:  state_nx = OUT_DRIVE;
                    OP_WRITE: state_nx = OUT_OFF;
                    default:  state_nx = OUT_HOLD;
                endcase
            end
            OUT_HOLD:  state_nx = (op == OP_READ) ? OUT_DRIVE : OUT_OFF;
            default:   state_nx = OUT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OUT_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        drive = (state == OUT_DRIVE) || (state == OUT_HOLD);
    end

    // R5: a captured read drives the bus after the next edge
    p_read_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |=> drive);

    // R9: a captured write releases the bus after the next edge
    p_write_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> !drive);

    // R8: first deselect after a read keeps driving
    p_desel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DESEL && state == OUT_DRIVE) |=> drive);

    // R8: two deselected cycles in a row release the bus
    p_desel_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DESEL && $past(op) == OP_DESEL) |=> !drive);
endmodule

// File: rtl/lane_sram.sv
module lane_sram
    import lane_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       gw_n,
    input  logic                       bwe_n,
    input  logic [LANES-1:0]           bw_n,
    input  logic                       oe_n,
    input  logic [LANES*LANE_BITS-1:0] dq_i,
    output logic [LANES*LANE_BITS-1:0] dq_o,
    output logic                       dq_oe
);
    localparam int W = LANES * LANE_BITS;

    logic [LANES-1:0]  lane_we;
    op_e               op_d, op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [W-1:0]      din_q;
    logic [LANES-1:0]  mask_q;
    logic [W-1:0]      rdata;
    logic              drive;

    lane_sram_wmask #(.LANES(LANES)) u_wmask (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    always_comb begin
        if (ce_n)          op_d = OP_DESEL;
        else if (|lane_we) op_d = OP_WRITE;
        else               op_d = OP_READ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_DESEL;
            addr_q <= '0;
            din_q  <= '0;
            mask_q <= '0;
        end else begin
            op_q   <= op_d;
            addr_q <= addr;
            din_q  <= dq_i;
            mask_q <= lane_we;
        end
    end

    lane_sram_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op_q),
        .addr  (addr_q),
        .wdata (din_q),
        .wmask (mask_q),
        .rdata (rdata)
    );

    lane_sram_outctl u_outctl (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op_q),
        .drive (drive)
    );

    assign dq_oe = drive && !oe_n;
    assign dq_o  = dq_oe ? rdata : '0;

    // R4: selected global write captures a write of every lane
    p_gw_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !gw_n) |=> (op_q == OP_WRITE && mask_q == {LANES{1'b1}}));

    // R11: a deselected cycle never becomes a write
    p_desel_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (op_q == OP_DESEL));
endmodule

// File: tb/tb_lane_sram.sv
module tb_lane_sram;
    localparam int LANES  = 4;
    localparam int ADDR_W = 5;
    localparam int W      = LANES * 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              gw_n = 1'b1;
    logic              bwe_n = 1'b1;
    logic [LANES-1:0]  bw_n = '1;
    logic              oe_n = 1'b0;
    logic [W-1:0]      dq_i = '0;
    logic [W-1:0]      dq_o;
    logic              dq_oe;

    int n_run = 0;
    int n_fail = 0;
    logic [W-1:0] model [1 << ADDR_W];

    always #4 clk = ~clk;

    lane_sram #(.LANES(LANES), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock cycle of stimulus; returns 1 ns after the capturing edge
    task automatic cyc(input logic c, input logic [ADDR_W-1:0] a, input logic g,
                       input logic be, input logic [LANES-1:0] b, input logic [W-1:0] d);
        ce_n = c; addr = a; gw_n = g; bwe_n = be; bw_n = b; dq_i = d;
        @(posedge clk);
        #1;
    endtask

    task automatic mwrite(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] lanes, input logic [W-1:0] d);
        for (int l = 0; l < LANES; l++)
            if (lanes[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
    endtask

    task automatic desel();
        cyc(1'b1, '0, 1'b1, 1'b1, '1, '0);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        cyc(1'b0, a, 1'b1, 1'b1, '1, '0);
    endtask

    task automatic t_reset();
        chk("R10 oe in reset", {35'd0, dq_oe}, '0);
        @(negedge clk); rst_n = 1'b1;
        desel(); desel();
        chk("R10 oe after reset", {35'd0, dq_oe}, '0);
        chk("R10 data after reset", dq_o, '0);
    endtask

    task automatic t_global();
        logic [W-1:0] d = 36'h9_A5C3_1E7F;
        cyc(1'b0, 5'd3, 1'b0, 1'b0, 4'b1110, d);   // gw overrides lane bits
        mwrite(5'd3, 4'b1111, d);
        desel();
        rd(5'd3);                                    // edge K
        desel();                                     // edge K+1
        chk("R4/R5 oe", {35'd0, dq_oe}, 36'd1);
        chk("R4/R5 data", dq_o, model[3]);
        desel();                                     // K+2: deselect from K+1 holds
        chk("R8 hold oe", {35'd0, dq_oe}, 36'd1);
        chk("R8 hold data", dq_o, model[3]);
        desel();                                     // K+3: released
        chk("R8 release", {35'd0, dq_oe}, '0);
    endtask

    task automatic t_bytes();
        logic [W-1:0] d0 = 36'h1_2345_6789;
        logic [W-1:0] d1 = 36'hF_EDCB_A987;
        cyc(1'b0, 5'd5, 1'b0, 1'b1, '1, d0);
        mwrite(5'd5, 4'b1111, d0);
        cyc(1'b0, 5'd5, 1'b1, 1'b0, 4'b1010, d1);   // lanes 0 and 2
        mwrite(5'd5, 4'b0101, d1);
        rd(5'd5);                                    // pass-through read
        desel();
        chk("R6/R2 merged", dq_o, model[5]);
        chk("R1 lane0", {27'd0, dq_o[8:0]}, {27'd0, d1[8:0]});
        chk("R1 lane3 parity", {35'd0, dq_o[35]}, {35'd0, d0[35]});
        desel();
    endtask

    task automatic t_commit();
        logic [W-1:0] d2 = 36'h3_0F0F_0F0F;
        logic [W-1:0] d3 = 36'hC_F0F0_F0F0;
        logic [W-1:0] d4 = 36'h5_5555_5555;
        cyc(1'b0, 5'd7, 1'b0, 1'b1, '1, d2);
        mwrite(5'd7, 4'b1111, d2);
        cyc(1'b0, 5'd7, 1'b1, 1'b0, 4'b0111, d4);   // only lane 3
        mwrite(5'd7, 4'b1000, d4);
        cyc(1'b0, 5'd8, 1'b0, 1'b1, '1, d3);        // drains addr 7 into the array
        mwrite(5'd8, 4'b1111, d3);
        rd(5'd7);
        desel();
        chk("R2 array partial", dq_o, model[7]);
        desel();
    endtask

    task automatic t_gated();
        cyc(1'b0, 5'd7, 1'b1, 1'b1, 4'b0000, 36'hF_FFFF_FFFF);
        desel();
        chk("R3 treated as read", dq_o, model[7]);
        rd(5'd7);
        desel();
        chk("R3 word unchanged", dq_o, model[7]);
        desel();
    endtask

    task automatic t_desel_write();
        cyc(1'b1, 5'd8, 1'b0, 1'b0, 4'b0000, 36'h0_0000_0001);
        rd(5'd8);
        desel();
        chk("R11 no write when deselected", dq_o, model[8]);
        desel();
    endtask

    task automatic t_oe();
        rd(5'd8);
        desel();
        oe_n = 1'b1; #1;
        chk("R7 oe_n off", {35'd0, dq_oe}, '0);
        chk("R7 data off", dq_o, '0);
        oe_n = 1'b0; #1;
        chk("R7 oe_n on", dq_o, model[8]);
        desel();
    endtask

    task automatic t_write_off();
        logic [W-1:0] d5 = 36'hA_BCDE_F012;
        rd(5'd3);                                    // edge K
        cyc(1'b0, 5'd9, 1'b0, 1'b1, '1, d5);        // edge K+1
        mwrite(5'd9, 4'b1111, d5);
        chk("R9 read still driven", dq_o, model[3]);
        desel();                                     // K+2
        chk("R9 write releases", {35'd0, dq_oe}, '0);
        rd(5'd9);
        desel();
        chk("R6 read after gap", dq_o, model[9]);
        desel();
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_global();
        t_bytes();
        t_commit();
        t_gated();
        t_desel_write();
        t_oe();
        t_write_off();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule